// File: doc/BRIEF.md
# ADC Input Scan Channel Sequencer

This block holds the 32-bit input-selection control word of an analog-to-digital converter and decides which positive and negative inputs, and which gain code, each conversion uses. Software writes the word through a simple write port and can read it back at any time. The converter signals the start of a conversion with a one-cycle strobe and its completion with another.

In scan mode, a non-zero scan length is programmed. The positive input is then the base channel plus a running offset. The offset steps up by one after every completed conversion. After the offset has moved scan-length steps past its programmed start, the next completion returns it to that start, so a fixed run of consecutive channels is converted round-robin. The selects and gain code are captured into output registers when a conversion starts and held for the whole conversion. Unused or impossible select codes are passed through unchanged and raised on flag outputs.

Top module: `adc_scan_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared. After reset, `rd_data`, `pos_sel`, `neg_sel`, `gain_code`, `sel_rsv` and `gain_rsv` are all zero.
- R2: A write (`wr_en` high at an edge) stores gain from bits 27:24, start offset from bits 23:20, scan length from bits 19:16, negative select from bits 12:8 and base positive channel from bits 4:0. `rd_data` returns these fields at the same positions, with the current offset in bits 23:20. Every other bit reads as zero.
- R3: At an edge where `conv_start` is high, `pos_sel` takes the low 5 bits of base channel plus current offset. At the same edge, `neg_sel` takes the negative select and `gain_code` takes the gain field. All of these use the values held before that edge. Without `conv_start`, all outputs keep their values.
- R4: With a non-zero scan length and no write, `conv_done` raises the offset by one, modulo 16, while fewer than scan-length steps have been taken since the start.
- R5: With a non-zero scan length, the `conv_done` that follows scan-length steps returns the offset to the start value last written. A scan therefore covers scan-length + 1 channels and then repeats.
- R6: When the scan length is zero, `conv_done` leaves the offset unchanged.
- R7: A write reloads the offset with the written start value and restarts the step count. A write has priority over a `conv_done` at the same edge.
- R8: `sel_rsv` is set at a conversion start if the positive select is 0x14–0x17 or 0x1D–0x1F. It is also set if the negative select is 0x08–0x17 or 0x1A–0x1F.
- R9: If base plus offset exceeds 0x1F at a conversion start, `sel_rsv` is set and `pos_sel` carries the low 5 bits of the sum.
- R10: `gain_rsv` is set at a conversion start when the gain code is 0x5–0xE. Codes 0x0–0x4 (1x to 16x) and 0xF (one-half) clear it. The code itself is passed through in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read-back |
| conv_start | input | 1 | Conversion-start strobe; captures the selects |
| conv_done | input | 1 | Conversion-done strobe; advances the scan |
| pos_sel | output | 5 | Registered positive mux select |
| neg_sel | output | 5 | Registered negative mux select |
| gain_code | output | 4 | Registered gain code |
| sel_rsv | output | 1 | Reserved or overflowing mux select captured |
| gain_rsv | output | 1 | Reserved gain code captured |

## Verification
The bench builds the block with its default widths: a 5-bit channel select, a 4-bit offset and scan length, and a 4-bit gain. With these widths, base plus offset can run past 0x1F and the offset can wrap from 15 to 0 inside a scan. Both corners are covered, along with every reserved code range. Directed sequences drive several scan lengths, start offsets, zero-length scans and a write colliding with a completion. A seeded random phase then mixes writes, starts and completions. A behavioural model checks every output on every clock.

// File: rtl/adc_scan_pkg.sv
// Package: widths and field positions of the input control word, and
// classification helpers for select and gain codes.
package adc_scan_pkg;
    parameter int DATA_W = 32;
    parameter int CH_W   = 5;
    parameter int OFS_W  = 4;
    parameter int GAIN_W = 4;

    // Field LSB positions inside the control word.
    localparam int GAIN_LSB = 24;
    localparam int OFS_LSB  = 20;
    localparam int SCAN_LSB = 16;
    localparam int NEG_LSB  = 8;
    localparam int POS_LSB  = 0;

    // True for unused positive select codes.
    function automatic logic pos_code_rsv(input logic [4:0] c);
        return ((c >= 5'h14) && (c <= 5'h17)) || (c >= 5'h1D);
    endfunction

    // True for unused negative select codes.
    function automatic logic neg_code_rsv(input logic [4:0] c);
        return ((c >= 5'h08) && (c <= 5'h17)) || (c >= 5'h1A);
    endfunction

    // True for unused gain codes.
    function automatic logic gain_code_rsv(input logic [3:0] g);
        return (g >= 4'h5) && (g <= 4'hE);
    endfunction
endpackage

// File: rtl/adc_scan_regs.sv
// Static fields of the control word: base positive channel, negative
// select, gain and scan length. Assumes a write takes effect at the edge
// where wr_en is high; the running offset lives in adc_scan_offset.
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CH_W,
    parameter int OW = OFS_W,
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] pos_base,
    output logic [CW-1:0] neg_q,
    output logic [GW-1:0] gain_q,
    output logic [OW-1:0] scan_len
);
    // Load all static fields on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_base <= '0;
            neg_q    <= '0;
            gain_q   <= '0;
            scan_len <= '0;
        end else if (wr_en) begin
            pos_base <= wr_data[POS_LSB  +: CW];
            neg_q    <= wr_data[NEG_LSB  +: CW];
            gain_q   <= wr_data[GAIN_LSB +: GW];
            scan_len <= wr_data[SCAN_LSB +: OW];
        end
    end

    p_write_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pos_base == $past(wr_data[POS_LSB +: CW])) &&
                  (scan_len == $past(wr_data[SCAN_LSB +: OW])));
    p_hold_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gain_q) && $stable(neg_q));
endmodule

// File: rtl/adc_scan_offset.sv
// Running scan offset. Steps once per completed conversion while the scan
// length is non-zero and returns to the written start after scan_len steps.
// Assumes wr_en and conv_done are single-cycle strobes; a write wins.
module adc_scan_offset
    import adc_scan_pkg::*;
#(
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_ofs,
    input  logic          conv_done,
    input  logic [OW-1:0] scan_len,
    output logic [OW-1:0] ofs_q
);
    logic [OW-1:0] start_q;
    logic [OW-1:0] step_q;
    logic          scan_on;
    logic          at_end;

    // Scan mode and end-of-run detection.
    always_comb begin
        scan_on = (scan_len != '0);
        at_end  = (step_q == scan_len);
    end

    // Offset, start value and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q   <= '0;
            start_q <= '0;
            step_q  <= '0;
        end else if (wr_en) begin
            ofs_q   <= wr_ofs;
            start_q <= wr_ofs;
            step_q  <= '0;
        end else if (conv_done && scan_on) begin
            if (at_end) begin
                ofs_q  <= start_q;
                step_q <= '0;
            end else begin
                ofs_q  <= ofs_q + 1'b1;
                step_q <= step_q + 1'b1;
            end
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conv_done && scan_len != '0 && step_q != scan_len)
        |=> ofs_q == $past(ofs_q) + 1'b1);
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conv_done && scan_len != '0 && step_q == scan_len)
        |=> ofs_q == $past(start_q));
    p_hold_noscan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && scan_len == '0) |=> $stable(ofs_q));
    p_write_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ofs_q == $past(wr_ofs)) && (step_q == '0));
endmodule

// File: rtl/adc_scan_select.sv
// Conversion-start capture of the mux selects and gain, with flags for
// unused codes and for a base-plus-offset sum beyond the select range.
// Assumes CW >= OW so the sum fits in CW+1 bits.
module adc_scan_select
    import adc_scan_pkg::*;
#(
    parameter int CW = CH_W,
    parameter int OW = OFS_W,
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_start,
    input  logic [CW-1:0] pos_base,
    input  logic [OW-1:0] ofs,
    input  logic [CW-1:0] neg,
    input  logic [GW-1:0] gain,
    output logic [CW-1:0] pos_sel,
    output logic [CW-1:0] neg_sel,
    output logic [GW-1:0] gain_code,
    output logic          sel_rsv,
    output logic          gain_rsv
);
    localparam int SUM_W = CW + 1;

    logic [SUM_W-1:0] pos_sum;
    logic             sum_ovf;
    logic             rsv_now;

    // Positive channel sum and reserved-select decision.
    always_comb begin
        pos_sum = {1'b0, pos_base} + SUM_W'(ofs);
        sum_ovf = pos_sum[CW];
        rsv_now = sum_ovf || pos_code_rsv(pos_sum[4:0]) || neg_code_rsv(neg[4:0]);
    end

    // Capture selects and flags when a conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_sel   <= '0;
            neg_sel   <= '0;
            gain_code <= '0;
            sel_rsv   <= 1'b0;
            gain_rsv  <= 1'b0;
        end else if (conv_start) begin
            pos_sel   <= pos_sum[CW-1:0];
            neg_sel   <= neg;
            gain_code <= gain;
            sel_rsv   <= rsv_now;
            gain_rsv  <= gain_code_rsv(gain[3:0]);
        end
    end

    p_hold_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable(pos_sel) && $stable(neg_sel) && $stable(gain_code));
    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && neg == 5'h09) |=> sel_rsv);
    p_overflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && ({1'b0, pos_base} + SUM_W'(ofs)) > SUM_W'(31)) |=> sel_rsv);
    p_gain_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> gain_code == $past(gain));
endmodule

// File: rtl/adc_scan_seq.sv
// Top of the input scan sequencer: control word storage, running offset
// and conversion-start capture. Assumes strobes are synchronous to clk.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CH_W,
    parameter int OW = OFS_W,
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          conv_start,
    input  logic          conv_done,
    output logic [CW-1:0] pos_sel,
    output logic [CW-1:0] neg_sel,
    output logic [GW-1:0] gain_code,
    output logic          sel_rsv,
    output logic          gain_rsv
);
    logic [CW-1:0] pos_base;
    logic [CW-1:0] neg_q;
    logic [GW-1:0] gain_q;
    logic [OW-1:0] scan_len;
    logic [OW-1:0] ofs_q;

    adc_scan_regs #(.DW(DW), .CW(CW), .OW(OW), .GW(GW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pos_base (pos_base),
        .neg_q    (neg_q),
        .gain_q   (gain_q),
        .scan_len (scan_len)
    );

    adc_scan_offset #(.OW(OW)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ofs    (wr_data[OFS_LSB +: OW]),
        .conv_done (conv_done),
        .scan_len  (scan_len),
        .ofs_q     (ofs_q)
    );

    adc_scan_select #(.CW(CW), .OW(OW), .GW(GW)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .pos_base   (pos_base),
        .ofs        (ofs_q),
        .neg        (neg_q),
        .gain       (gain_q),
        .pos_sel    (pos_sel),
        .neg_sel    (neg_sel),
        .gain_code  (gain_code),
        .sel_rsv    (sel_rsv),
        .gain_rsv   (gain_rsv)
    );

    // Assemble the read-back word; unused bits are zero.
    always_comb begin
        rd_data = '0;
        rd_data[GAIN_LSB +: GW] = gain_q;
        rd_data[OFS_LSB  +: OW] = ofs_q;
        rd_data[SCAN_LSB +: OW] = scan_len;
        rd_data[NEG_LSB  +: CW] = neg_q;
        rd_data[POS_LSB  +: CW] = pos_base;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && (pos_sel == '0) && !sel_rsv && !gain_rsv);
endmodule

// File: tb/tb_adc_scan_seq.sv
// Bench: behavioural model of the sequencer, compared on every clock.
module tb_adc_scan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [31:0] rd_data;
    logic [4:0]  pos_sel, neg_sel;
    logic [3:0]  gain_code;
    logic        sel_rsv, gain_rsv;

    int n_vec = 0;
    int n_bad = 0;

    // Model state.
    int m_pos, m_neg, m_gain, m_scan, m_ofs, m_start, m_step;
    int o_pos, o_neg, o_gain, o_srsv, o_grsv;

    always #5 clk = ~clk;

    adc_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .conv_start(conv_start), .conv_done(conv_done),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .gain_code(gain_code),
        .sel_rsv(sel_rsv), .gain_rsv(gain_rsv)
    );

    function automatic int rsv_pos(int c);
        return ((c >= 'h14 && c <= 'h17) || c >= 'h1D) ? 1 : 0;
    endfunction
    function automatic int rsv_neg(int c);
        return ((c >= 'h08 && c <= 'h17) || c >= 'h1A) ? 1 : 0;
    endfunction

    task automatic model_reset();
        m_pos = 0; m_neg = 0; m_gain = 0; m_scan = 0; m_ofs = 0; m_start = 0; m_step = 0;
        o_pos = 0; o_neg = 0; o_gain = 0; o_srsv = 0; o_grsv = 0;
    endtask

    // Advance the model by one clock using the inputs held at this edge.
    task automatic model_step();
        int sum;
        if (!rst_n) begin
            model_reset();
            return;
        end
        if (conv_start) begin
            sum = m_pos + m_ofs;
            o_pos  = sum % 32;
            o_neg  = m_neg;
            o_gain = m_gain;
            o_srsv = (sum > 31 || rsv_pos(sum % 32) != 0 || rsv_neg(m_neg) != 0) ? 1 : 0;
            o_grsv = (m_gain >= 5 && m_gain <= 14) ? 1 : 0;
        end
        if (wr_en) begin
            m_gain  = int'(wr_data[27:24]);
            m_ofs   = int'(wr_data[23:20]);
            m_start = m_ofs;
            m_scan  = int'(wr_data[19:16]);
            m_neg   = int'(wr_data[12:8]);
            m_pos   = int'(wr_data[4:0]);
            m_step  = 0;
        end else if (conv_done && m_scan != 0) begin
            if (m_step == m_scan) begin
                m_ofs = m_start; m_step = 0;
            end else begin
                m_ofs = (m_ofs + 1) % 16; m_step++;
            end
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model (called away from the edge).
    task automatic compare();
        int exp_rd;
        exp_rd = (m_gain << 24) | (m_ofs << 20) | (m_scan << 16) | (m_neg << 8) | m_pos;
        check("R2/R4/R5/R6/R7", "rd_data", int'(rd_data), exp_rd);
        check("R3/R9", "pos_sel", int'(pos_sel), o_pos);
        check("R3", "neg_sel", int'(neg_sel), o_neg);
        check("R10", "gain_code", int'(gain_code), o_gain);
        check("R8/R9", "sel_rsv", int'(sel_rsv), o_srsv);
        check("R10", "gain_rsv", int'(gain_rsv), o_grsv);
    endtask

    // One clock: drive at the falling edge, update model at the rising edge, compare.
    task automatic cyc(bit w, logic [31:0] d, bit s, bit dn);
        wr_en = w; wr_data = d; conv_start = s; conv_done = dn;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    function automatic logic [31:0] word(int gain, int ofs, int scan, int neg, int pos);
        return 32'((gain << 24) | (ofs << 20) | (scan << 16) | (neg << 8) | pos);
    endfunction

    // One full conversion: start, idle, done.
    task automatic conv();
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 0);
        cyc(0, '0, 0, 1);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        cyc(0, '0, 0, 0);
        cyc(0, '0, 0, 0);
        // R1: reset state.
        check("R1", "rd_data reset", int'(rd_data), 0);
        check("R1", "pos_sel reset", int'(pos_sel), 0);
        rst_n = 1'b1;
        // R2: field positions, unused bits dropped.
        cyc(1, 32'hF3F1_E9E3, 0, 0);
        cyc(0, '0, 0, 0);
        // R4 and R5: scan of 4 channels from base 4, start offset 2.
        cyc(1, word(1, 2, 3, 0, 4), 0, 0);
        for (int i = 0; i < 10; i++) conv();
        // R6: zero scan length holds the offset.
        cyc(1, word(2, 5, 0, 3, 6), 0, 0);
        for (int i = 0; i < 3; i++) conv();
        // R4 modulo wrap and R5 return: offset 14, scan 3.
        cyc(1, word(4, 14, 3, 7, 1), 0, 0);
        for (int i = 0; i < 6; i++) conv();
        // R9: sum past 0x1F.
        cyc(1, word(0, 3, 2, 0, 'h1E), 0, 0);
        for (int i = 0; i < 3; i++) conv();
        // R8: reserved negative, reserved positive, ground codes.
        cyc(1, word(0, 0, 0, 'h10, 'h02), 0, 0);
        conv();
        cyc(1, word(0, 0, 0, 'h18, 'h15), 0, 0);
        conv();
        cyc(1, word(0, 0, 0, 'h19, 'h1C), 0, 0);
        conv();
        // R10: gain codes 7, F, 4.
        cyc(1, word(7, 0, 0, 0, 0), 0, 0);
        conv();
        cyc(1, word(15, 0, 0, 0, 0), 0, 0);
        conv();
        cyc(1, word(4, 0, 0, 0, 0), 0, 0);
        conv();
        // R7: write collides with done, and with start.
        cyc(1, word(0, 1, 4, 0, 2), 0, 0);
        conv(); conv();
        cyc(1, word(0, 9, 2, 0, 3), 1, 1);
        conv();
        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(($urandom % 8) == 0, r, ($urandom % 3) == 0, ($urandom % 3) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule